// File: doc/BRIEF.md
# Supervisory Operating-Mode Controller

This block sequences a battery supervisor through four operating modes: fully off, ramping up, running, and a low-power nap. It watches a single combined supply-good flag, a small control register written over the serial interface, an external wake pin and two fault flags. From these it drives the enables for the bias network, the internal regulator, the serial interface and the protection circuits. It also drives the charge and discharge switch drivers, the cell-balancing outputs and a register-clear strobe.

When any rail drops, the block falls back to the off mode and wipes its control register. When power returns, the block passes through a fixed settling window before it runs. While running, the switches and balancing follow software command bits, subject to the fault flags. Software parks the block in nap by setting the nap bit. The block returns to running when either edge arrives on the wake pin or when software clears the bit. On that return, all power switches are off and the nap bit has been cleared by hardware.

Top module: `pm_mode_ctrl`

## Requirements
- R1: The `mode` output encodes 00 off, 01 ramp, 10 run, 11 nap. Reset gives off. A low `supply_ok` seen at any clock edge puts the block in off at that edge, from every mode.
- R2: In off, `bias_en`, `vreg_en`, `serial_en` and `prot_en` are low and `regs_clr` is high. The control register reads zero from the next cycle on, and writes made in off are ignored.
- R3: A high `supply_ok` in off moves the block to ramp at the next edge. In ramp, bias, regulator and serial are enabled and protection is off. Ramp lasts exactly SETTLE_CYC cycles before run.
- R4: In run, bias, regulator, serial and protection are enabled. The control register has these fields: bit 0 charge, bit 1 discharge, bit 2 balance, bit 3 nap. `chg_drv`, `dis_drv` and `bal_en` follow bits 0, 1 and 2, and all of them are low on first entry to run.
- R5: While `oc_fault` is high, `chg_drv` and `dis_drv` are low in the same cycle, and `bal_en` is unaffected.
- R6: While `ot_fault` is high, `chg_drv`, `dis_drv` and `bal_en` are all low in the same cycle.
- R7: A nap bit of 1 in run moves the block to nap at the next edge. In nap, only `serial_en` stays high, and every other enable and driver is low.
- R8: In nap, a rising or a falling transition on `wake_pin` brings the block back to run at the third clock edge after the transition. At that edge, hardware clears the nap bit.
- R9: In nap, software writing the nap bit to 0 brings the block back to run at the edge after the write.
- R10: In nap, control bits 0 to 2 are held at zero and writes to them are ignored, so run after nap starts with every switch off.
- R11: Wake-pin transitions outside nap have no effect on the mode or on the control register.
- R12: If a wake transition and a software write of nap=1 fall in the same cycle during nap, the wake wins: the block goes to run and the nap bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | High when every monitored rail is above its minimum |
| wake_pin | input | 1 | Asynchronous wake request, either edge |
| cfg_wr | input | 1 | Control-register write strobe |
| cfg_wdata | input | 4 | Control-register write data |
| oc_fault | input | 1 | Over-current flag |
| ot_fault | input | 1 | Over-temperature flag |
| cfg_rdata | output | 4 | Control-register contents |
| mode | output | 2 | Current operating mode |
| bias_en | output | 1 | Bias network enable |
| vreg_en | output | 1 | Regulator enable |
| serial_en | output | 1 | Serial interface enable |
| prot_en | output | 1 | Protection circuit enable |
| regs_clr | output | 1 | Register clear strobe |
| chg_drv | output | 1 | Charge switch drive |
| dis_drv | output | 1 | Discharge switch drive |
| bal_en | output | 1 | Balancing outputs enable |

## Verification
The two functions that can meet in one cycle are the hardware clear of the nap bit on a wake edge and a software write that sets the same bit. The bench toggles the wake pin while in nap and counts two edges through the synchronizer. It then holds a write of nap=1 so that it lands on the edge where the wake is acted on. The result is judged by the mode reading run at that edge, by the nap bit reading 0, and by run still holding several cycles later. A lost clear would make the block drop straight back into nap.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PM_OFF  = 2'b00,
        PM_RAMP = 2'b01,
        PM_RUN  = 2'b10,
        PM_NAP  = 2'b11
    } pm_mode_e;

    localparam int CFG_W  = 4;
    localparam int CB_CHG = 0;
    localparam int CB_DIS = 1;
    localparam int CB_BAL = 2;
    localparam int CB_NAP = 3;

    typedef struct packed {
        logic bias;
        logic vreg;
        logic serial;
        logic prot;
        logic clr;
        logic sw_ok;
    } pm_en_t;

    typedef struct packed {
        logic chg;
        logic dis;
        logic bal;
    } pm_drv_t;

    function automatic pm_en_t mode_enables(pm_mode_e m);
        pm_en_t e;
        e = '0;
        case (m)
            PM_OFF:  e.clr = 1'b1;
            PM_RAMP: begin
                e.bias   = 1'b1;
                e.vreg   = 1'b1;
                e.serial = 1'b1;
            end
            PM_RUN: begin
                e.bias   = 1'b1;
                e.vreg   = 1'b1;
                e.serial = 1'b1;
                e.prot   = 1'b1;
                e.sw_ok  = 1'b1;
            end
            PM_NAP:  e.serial = 1'b1;
            default: e.clr = 1'b1;
        endcase
        return e;
    endfunction

    function automatic pm_drv_t gate_drivers(logic [CFG_W-1:0] cfg, logic allow,
                                             logic oc, logic ot);
        pm_drv_t d;
        d.chg = allow & cfg[CB_CHG] & ~oc & ~ot;
        d.dis = allow & cfg[CB_DIS] & ~oc & ~ot;
        d.bal = allow & cfg[CB_BAL] & ~ot;
        return d;
    endfunction

endpackage

// File: rtl/pm_wake_edge.sv
module pm_wake_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic evt
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign evt = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/pm_seq_fsm.sv
module pm_seq_fsm
    import pm_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     supply_ok,
    input  logic     nap_bit,
    input  logic     wake_evt,
    output pm_mode_e mode_q
);
    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    pm_mode_e         mode_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        mode_d = mode_q;
        cnt_d  = '0;
        if (!supply_ok) begin
            mode_d = PM_OFF;
        end else begin
            case (mode_q)
                PM_OFF:  mode_d = PM_RAMP;
                PM_RAMP: begin
                    if (cnt_q == CNT_LAST) mode_d = PM_RUN;
                    else                   cnt_d  = cnt_q + 1'b1;
                end
                PM_RUN:  if (nap_bit) mode_d = PM_NAP;
                PM_NAP:  if (wake_evt || !nap_bit) mode_d = PM_RUN;
                default: mode_d = PM_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_OFF;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/pm_cfg_reg.sv
module pm_cfg_reg
    import pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  pm_mode_e         mode,
    input  logic             wake_evt,
    output logic [CFG_W-1:0] q
);
    logic [CFG_W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (wr) nxt = wdata;
        if (mode == PM_NAP) begin
            nxt[CB_CHG] = 1'b0;
            nxt[CB_DIS] = 1'b0;
            nxt[CB_BAL] = 1'b0;
            if (wake_evt) nxt[CB_NAP] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else            q <= nxt;
    end
endmodule

// File: rtl/pm_out_gate.sv
module pm_out_gate
    import pm_pkg::*;
(
    input  pm_mode_e         mode,
    input  logic [CFG_W-1:0] cfg,
    input  logic             oc_fault,
    input  logic             ot_fault,
    output logic             bias_en,
    output logic             vreg_en,
    output logic             serial_en,
    output logic             prot_en,
    output logic             regs_clr,
    output logic             chg_drv,
    output logic             dis_drv,
    output logic             bal_en
);
    pm_en_t  en;
    pm_drv_t drv;

    always_comb begin
        en  = mode_enables(mode);
        drv = gate_drivers(cfg, en.sw_ok, oc_fault, ot_fault);
    end

    assign bias_en   = en.bias;
    assign vreg_en   = en.vreg;
    assign serial_en = en.serial;
    assign prot_en   = en.prot;
    assign regs_clr  = en.clr;
    assign chg_drv   = drv.chg;
    assign dis_drv   = drv.dis;
    assign bal_en    = drv.bal;
endmodule

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl
    import pm_pkg::*;
#(
    parameter int SETTLE_CYC  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic             wake_pin,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             oc_fault,
    input  logic             ot_fault,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic [1:0]       mode,
    output logic             bias_en,
    output logic             vreg_en,
    output logic             serial_en,
    output logic             prot_en,
    output logic             regs_clr,
    output logic             chg_drv,
    output logic             dis_drv,
    output logic             bal_en
);
    pm_mode_e         mode_q;
    logic             wake_evt;
    logic [CFG_W-1:0] cfg_q;
    logic             clr_w;

    pm_wake_edge #(.STAGES(SYNC_STAGES)) u_wake (
        .clk (clk),
        .rst (rst),
        .pin (wake_pin),
        .evt (wake_evt)
    );

    pm_seq_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .nap_bit   (cfg_q[CB_NAP]),
        .wake_evt  (wake_evt),
        .mode_q    (mode_q)
    );

    pm_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_w),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .mode     (mode_q),
        .wake_evt (wake_evt),
        .q        (cfg_q)
    );

    pm_out_gate u_gate (
        .mode      (mode_q),
        .cfg       (cfg_q),
        .oc_fault  (oc_fault),
        .ot_fault  (ot_fault),
        .bias_en   (bias_en),
        .vreg_en   (vreg_en),
        .serial_en (serial_en),
        .prot_en   (prot_en),
        .regs_clr  (clr_w),
        .chg_drv   (chg_drv),
        .dis_drv   (dis_drv),
        .bal_en    (bal_en)
    );

    assign regs_clr  = clr_w;
    assign cfg_rdata = cfg_q;
    assign mode      = mode_q;
endmodule

// File: rtl/pm_mode_chk.sv
module pm_mode_chk #(
    parameter int SETTLE_CYC = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok,
    input logic       oc_fault,
    input logic       ot_fault,
    input logic [3:0] cfg_rdata,
    input logic [1:0] mode,
    input logic       bias_en,
    input logic       vreg_en,
    input logic       serial_en,
    input logic       prot_en,
    input logic       chg_drv,
    input logic       dis_drv,
    input logic       bal_en
);
    int unsigned ramp_len;

    always_ff @(posedge clk) begin
        if (rst)                ramp_len <= 0;
        else if (mode == 2'b01) ramp_len <= ramp_len + 1;
        else                    ramp_len <= 0;
    end

    // R1
    supply_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> mode == 2'b00);

    // R2
    off_clears_chk: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b00 |=> cfg_rdata == 4'b0000);

    // R3
    ramp_length_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == 2'b01 && mode == 2'b10) |-> ramp_len == SETTLE_CYC);

    // R4
    switches_run_only_chk: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b10 |-> !chg_drv && !dis_drv && !bal_en);

    // R5
    oc_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
        oc_fault |-> !chg_drv && !dis_drv);

    // R6
    ot_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
        ot_fault |-> !chg_drv && !dis_drv && !bal_en);

    // R7
    nap_enables_chk: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b11 |-> serial_en && !bias_en && !vreg_en && !prot_en);

    // R10
    nap_exit_clean_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == 2'b11 && mode == 2'b10) |-> cfg_rdata[2:0] == 3'b000);
endmodule

bind pm_mode_ctrl pm_mode_chk #(.SETTLE_CYC(SETTLE_CYC)) u_pm_mode_chk (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .oc_fault  (oc_fault),
    .ot_fault  (ot_fault),
    .cfg_rdata (cfg_rdata),
    .mode      (mode),
    .bias_en   (bias_en),
    .vreg_en   (vreg_en),
    .serial_en (serial_en),
    .prot_en   (prot_en),
    .chg_drv   (chg_drv),
    .dis_drv   (dis_drv),
    .bal_en    (bal_en)
);

// File: tb/test_pm_mode_ctrl.sv
module test_pm_mode_ctrl;
    localparam int SETTLE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok = 1'b0;
    logic       wake_pin = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_wdata = 4'b0000;
    logic       oc_fault = 1'b0;
    logic       ot_fault = 1'b0;
    logic [3:0] cfg_rdata;
    logic [1:0] mode;
    logic       bias_en, vreg_en, serial_en, prot_en, regs_clr;
    logic       chg_drv, dis_drv, bal_en;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    pm_mode_ctrl #(.SETTLE_CYC(SETTLE)) i_pm_mode_ctrl (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .wake_pin  (wake_pin),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .oc_fault  (oc_fault),
        .ot_fault  (ot_fault),
        .cfg_rdata (cfg_rdata),
        .mode      (mode),
        .bias_en   (bias_en),
        .vreg_en   (vreg_en),
        .serial_en (serial_en),
        .prot_en   (prot_en),
        .regs_clr  (regs_clr),
        .chg_drv   (chg_drv),
        .dis_drv   (dis_drv),
        .bal_en    (bal_en)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_cfg(logic [3:0] d);
        cfg_wr    = 1'b1;
        cfg_wdata = d;
        tick();
        cfg_wr    = 1'b0;
    endtask

    function automatic logic [3:0] pwr_vec();
        return {bias_en, vreg_en, serial_en, prot_en};
    endfunction

    function automatic logic [2:0] drv_vec();
        return {chg_drv, dis_drv, bal_en};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        tick(3);
        check("R1 reset mode", mode, 2'b00);
        check("R2 off enables", pwr_vec(), 4'b0000);
        check("R2 off clear strobe", regs_clr, 1'b1);
        check("R2 off reg zero", cfg_rdata, 4'h0);
        rst = 1'b0;
        tick();
        write_cfg(4'b0111);
        check("R2 write in off ignored", cfg_rdata, 4'h0);
    endtask

    task automatic t_ramp();
        supply_ok = 1'b1;
        tick();
        check("R3 ramp entered", mode, 2'b01);
        check("R3 ramp enables", pwr_vec(), 4'b1110);
        check("R3 ramp no clear", regs_clr, 1'b0);
        for (int i = 2; i <= SETTLE; i++) begin
            tick();
            check("R3 ramp held", mode, 2'b01);
        end
        tick();
        check("R3 run after settle", mode, 2'b10);
        check("R4 run enables", pwr_vec(), 4'b1111);
        check("R4 switches off at entry", drv_vec(), 3'b000);
    endtask

    task automatic t_cmds();
        write_cfg(4'b0101);
        check("R4 charge+balance", drv_vec(), 3'b101);
        write_cfg(4'b0011);
        check("R4 charge+discharge", drv_vec(), 3'b110);
    endtask

    task automatic t_faults();
        write_cfg(4'b0111);
        check("R4 all on", drv_vec(), 3'b111);
        oc_fault = 1'b1; #1;
        check("R5 over-current", drv_vec(), 3'b001);
        oc_fault = 1'b0; ot_fault = 1'b1; #1;
        check("R6 over-temperature", drv_vec(), 3'b000);
        ot_fault = 1'b0; #1;
        check("R5 fault released", drv_vec(), 3'b111);
    endtask

    task automatic t_wake_in_run();
        wake_pin = ~wake_pin;
        tick(5);
        check("R11 wake in run mode", mode, 2'b10);
        check("R11 wake in run reg", cfg_rdata, 4'b0111);
    endtask

    task automatic t_nap_wake();
        write_cfg(4'b1111);
        check("R7 still run after write", mode, 2'b10);
        tick();
        check("R7 nap entered", mode, 2'b11);
        check("R7 nap enables", pwr_vec(), 4'b0010);
        check("R7 nap drivers", drv_vec(), 3'b000);
        tick();
        check("R10 nap clears cmd bits", cfg_rdata, 4'b1000);
        write_cfg(4'b1111);
        check("R10 nap write ignored", cfg_rdata, 4'b1000);
        wake_pin = ~wake_pin;
        tick(2);
        check("R8 still nap before sync", mode, 2'b11);
        tick();
        check("R8 wake to run", mode, 2'b10);
        check("R8 nap bit cleared", cfg_rdata, 4'b0000);
        check("R10 switches off after nap", drv_vec(), 3'b000);
        tick(3);
        check("R8 stays run", mode, 2'b10);
    endtask

    task automatic t_sw_exit();
        write_cfg(4'b1000);
        tick();
        check("R9 nap entered", mode, 2'b11);
        write_cfg(4'b0000);
        check("R9 still nap at write edge", mode, 2'b11);
        tick();
        check("R9 software exit", mode, 2'b10);
    endtask

    task automatic t_collide();
        write_cfg(4'b1000);
        tick();
        check("R12 nap entered", mode, 2'b11);
        wake_pin = ~wake_pin;
        tick(2);
        write_cfg(4'b1000);
        check("R12 wake wins mode", mode, 2'b10);
        check("R12 nap bit cleared", cfg_rdata, 4'b0000);
        tick(3);
        check("R12 run holds", mode, 2'b10);
    endtask

    task automatic t_drop();
        write_cfg(4'b0111);
        supply_ok = 1'b0;
        tick();
        check("R1 drop from run", mode, 2'b00);
        check("R2 clear strobe", regs_clr, 1'b1);
        check("R2 drivers off", drv_vec(), 3'b000);
        tick();
        check("R2 reg cleared", cfg_rdata, 4'h0);
        supply_ok = 1'b1;
        tick(SETTLE + 1);
        check("R3 repower run", mode, 2'b10);
        write_cfg(4'b1000);
        tick();
        check("R1 nap before drop", mode, 2'b11);
        supply_ok = 1'b0;
        tick();
        check("R1 drop from nap", mode, 2'b00);
        supply_ok = 1'b1;
        tick();
        supply_ok = 1'b0;
        tick();
        check("R1 drop from ramp", mode, 2'b00);
    endtask

    initial begin
        t_reset();
        t_ramp();
        t_cmds();
        t_faults();
        t_wake_in_run();
        t_nap_wake();
        write_cfg(4'b0111);
        t_nap_wake();
        t_sw_exit();
        t_collide();
        t_drop();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule